// File: doc/BRIEF.md
# Speculative Predicate Release and Verification Unit

This unit sits beside an instruction window and tracks the predicate-producing test instructions of one in-flight block. When the block's predicted predicate bitmap and its confidence bitmap arrive, each entry captures one prediction bit and one confidence bit. Every confident entry releases its predicted value to its consumers at once, without waiting for the test's operands. Entries without confidence wait: they release a predicate only when the test instruction really executes.

Speculated tests still execute. Their real result is checked against the stored prediction. A match is silent, because the consumers already hold the right value. A mismatch produces a one-cycle flush request that names the failing entry, and the block stops reacting to results until it is reloaded. On the refetch the window raises the no-predict input with the load. That clears every confidence bit, so the whole block resolves on real results only.

Top module: `spec_pred_gate`

## Requirements
- R1: After reset no delivery strobe and no flush request is active, and results that arrive before the first load produce no event.
- R2: A load captures bitmap bit i into entry i. In the cycle after the load, `dlv_valid` equals the confidence bitmap and `dlv_val` equals prediction AND confidence. All confident entries deliver together.
- R3: An entry whose confidence bit is clear delivers nothing at load time. It delivers the real result value on bit `res_idx` in the cycle after that result arrives.
- R4: A real result that matches the prediction of a confident entry produces no delivery and no flush.
- R5: A real result that differs from the prediction of a confident entry raises `flush_req` for exactly one cycle, in the cycle after the result, with `flush_idx` equal to that entry and no delivery in that cycle.
- R6: When `no_predict` is high at load, every confidence bit is stored as zero. Nothing is delivered at load, and every entry then behaves as in R3.
- R7: Each entry resolves at most once per load. A further result for an already resolved entry produces no event.
- R8: After a flush, every result is ignored until the next load.
- R9: A result presented in the same cycle as a load is dropped, and the new block's entry stays unresolved.
- R10: Output fields that carry no event read zero: `dlv_val` bits whose `dlv_valid` bit is low, and `flush_idx` while `flush_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | New block bitmaps present this cycle |
| load_pred | input | NPRED | Predicted predicate values, bit i for test i |
| load_conf | input | NPRED | Confidence per predicted predicate |
| no_predict | input | 1 | Refetch mode: ignore all confidence at this load |
| res_valid | input | 1 | A test instruction produced its real result |
| res_idx | input | IW | Index of the test that produced the result |
| res_val | input | 1 | Real predicate value |
| dlv_valid | output | NPRED | Per-entry predicate delivery strobe |
| dlv_val | output | NPRED | Per-entry delivered predicate value |
| flush_req | output | 1 | Misspeculation: flush and refetch without prediction |
| flush_idx | output | IW | Entry whose prediction failed |

## Verification
The bench walks every prediction, confidence and no-predict combination of a four-entry block. It resolves the entries in order with a mix of matching and failing results. A unit that re-delivered a confirmed speculated predicate would show extra strobes after a match. One that kept working after a flush would emit a second flush or late deliveries. One that honoured confidence in refetch mode would deliver at load. Duplicate results, results before any load, and results that collide with a load are driven too. An implementation that let them through would resolve entries twice or lose the first real result of the next block.

// File: rtl/spec_pred_gate.sv
module spec_pred_gate #(
  parameter int NPRED = 4,
  localparam int IW = (NPRED > 1) ? $clog2(NPRED) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [NPRED-1:0] load_pred,
  input  logic [NPRED-1:0] load_conf,
  input  logic             no_predict,
  input  logic             res_valid,
  input  logic [IW-1:0]    res_idx,
  input  logic             res_val,
  output logic [NPRED-1:0] dlv_valid,
  output logic [NPRED-1:0] dlv_val,
  output logic             flush_req,
  output logic [IW-1:0]    flush_idx
);

  logic [NPRED-1:0] ent_pred, ent_conf, ent_done;
  logic             blk_live;

  logic [NPRED-1:0] conf_eff, sel, hit, miss, dv_n, dval_n;
  logic             res_ok, flush_n;

  assign conf_eff = load_conf & {NPRED{~no_predict}};
  assign sel      = NPRED'(1) << res_idx;
  assign res_ok   = res_valid & ~load_valid & blk_live;

  for (genvar i = 0; i < NPRED; i++) begin : g_ent
    assign hit[i]    = res_ok & sel[i] & ~ent_done[i];
    assign miss[i]   = hit[i] & ent_conf[i] & (res_val ^ ent_pred[i]);
    assign dv_n[i]   = load_valid ? conf_eff[i] : (hit[i] & ~ent_conf[i]);
    assign dval_n[i] = load_valid ? (conf_eff[i] & load_pred[i])
                                  : (hit[i] & ~ent_conf[i] & res_val);
  end

  assign flush_n = |miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_pred  <= '0;
      ent_conf  <= '0;
      ent_done  <= '0;
      blk_live  <= 1'b0;
      dlv_valid <= '0;
      dlv_val   <= '0;
      flush_req <= 1'b0;
      flush_idx <= '0;
    end else begin
      dlv_valid <= dv_n;
      dlv_val   <= dval_n;
      flush_req <= flush_n;
      flush_idx <= flush_n ? res_idx : '0;
      if (load_valid) begin
        ent_pred <= load_pred;
        ent_conf <= conf_eff;
        ent_done <= '0;
        blk_live <= 1'b1;
      end else begin
        ent_done <= ent_done | hit;
        if (flush_n) blk_live <= 1'b0;
      end
    end
  end

  a_r6_no_predict_silent: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid && no_predict |=> dlv_valid == '0);

  a_r3_unconfident_waits: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> (dlv_valid & ~$past(load_conf)) == '0);

  a_r5_flush_alone: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> dlv_valid == '0);

  a_r8_single_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> !flush_req);

  a_r1_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !load_valid && !blk_live |=> !flush_req && dlv_valid == '0);

  a_r10_quiet_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_val & ~dlv_valid) == '0 && (flush_req || flush_idx == '0));

endmodule

// File: tb/test_spec_pred_gate.sv
module test_spec_pred_gate;
  localparam int N  = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_valid = 1'b0, no_predict = 1'b0, res_valid = 1'b0, res_val = 1'b0;
  logic [N-1:0] load_pred = '0, load_conf = '0;
  logic [IW-1:0] res_idx = '0;
  logic [N-1:0] dlv_valid, dlv_val;
  logic flush_req;
  logic [IW-1:0] flush_idx;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spec_pred_gate #(.NPRED(N)) i_spec_pred_gate (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_pred(load_pred),
    .load_conf(load_conf), .no_predict(no_predict), .res_valid(res_valid),
    .res_idx(res_idx), .res_val(res_val), .dlv_valid(dlv_valid), .dlv_val(dlv_val),
    .flush_req(flush_req), .flush_idx(flush_idx));

  task automatic check(string tag, logic [10:0] exp);
    logic [10:0] act;
    act = {dlv_valid, dlv_val, flush_req, flush_idx};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] pack(logic [N-1:0] v, logic [N-1:0] d, logic f, logic [IW-1:0] fi);
    return {v, d, f, fi};
  endfunction

  task automatic step(logic lv, logic [N-1:0] lp, logic [N-1:0] lc, logic np,
                      logic rv, logic [IW-1:0] ri, logic rvl);
    load_valid = lv; load_pred = lp; load_conf = lc; no_predict = np;
    res_valid = rv; res_idx = ri; res_val = rvl;
    @(negedge clk);
    load_valid = 0; load_pred = '0; load_conf = '0; no_predict = 0;
    res_valid = 0; res_idx = '0; res_val = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", '0);
    step(0, '0, '0, 0, 1, 2'd1, 1);
    check("R1 result before any load", '0);

    // R9: collision with load drops the result; entry 0 still unresolved
    step(1, 4'b0000, 4'b0000, 0, 1, 2'd0, 1);
    check("R9 collision dropped", '0);
    step(0, '0, '0, 0, 1, 2'd0, 1);
    check("R9 entry resolves later", pack(4'b0001, 4'b0001, 0, 0));

    for (int p = 0; p < 16; p++)
      for (int c = 0; c < 16; c++)
        for (int np = 0; np < 2; np++) begin
          logic [N-1:0] ceff, flip;
          bit flushed;
          ceff = np ? 4'b0 : 4'(c);
          flip = 4'((p * 5 + c * 3 + np) & 15);
          flushed = 0;
          step(1, 4'(p), 4'(c), 1'(np), 0, '0, 0);
          check(np ? "R6 no-predict load" : "R2 load release",
                pack(ceff, ceff & 4'(p), 0, 0));
          for (int i = 0; i < N; i++) begin
            logic rv;
            logic [N-1:0] bit_i;
            rv = 1'(p >> i) ^ flip[i];
            bit_i = 4'(1 << i);
            step(0, '0, '0, 0, 1, 2'(i), rv);
            if (flushed) check("R8 after flush", '0);
            else if (ceff[i] && flip[i]) begin
              check("R5 mismatch flush", pack('0, '0, 1, 2'(i)));
              flushed = 1;
            end else if (ceff[i]) check("R4 match silent", '0);
            else check("R3 real result delivery", pack(bit_i, rv ? bit_i : '0, 0, 0));
          end
          step(0, '0, '0, 0, 1, 2'd0, ~(1'(p) ^ flip[0]));
          check("R7 duplicate result", '0);
          check("R10 fields quiet", '0);
        end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule